// File: doc/BRIEF.md
# Signed/Unsigned 8x8 Multiply Unit

This unit multiplies two 8-bit operands and leaves the 16-bit result in two readable 8-bit product registers, one for the upper byte and one for the lower byte. A request is a one-cycle `start` strobe together with a mode select. In unsigned mode the product is written on the clock edge that accepts the request, so the result and a one-cycle `done` pulse appear in the very next cycle. Unsigned requests can be issued on every cycle.

In signed mode the operands are captured and passed through the same unsigned array. A fixed sequence then corrects the upper product byte. If the second operand is negative, the first operand is subtracted from the upper byte. After that, if the first operand is negative, the second operand is subtracted from the upper byte. Each subtraction wraps modulo 256 and never touches the lower byte. The result is the two's-complement product.

The sequence always takes six cycles, whatever the sign bits are. `busy` is high for the whole of it, and further requests are ignored until it ends. The product registers can be read at any time, including partway through the sequence.

Top module: `mul8_sc`

## Requirements
- R1: After reset `prod_hi` and `prod_lo` are 0x00, and `busy` and `done` are 0.
- R2: A request accepted with `mode_sgn`=0 writes the unsigned product {`prod_hi`,`prod_lo`} = `opa` x `opb` on the accepting edge. `done` is 1 in the following cycle and `busy` stays 0, so requests can follow on consecutive cycles.
- R3: A request with `mode_sgn`=1 leaves {`prod_hi`,`prod_lo`} equal to the 16-bit two's-complement product of `opa` and `opb`, with bit 7 of each operand as its sign. `prod_lo` equals the low byte of the unsigned product.
- R4: A signed request keeps `busy` at 1 for exactly six cycles after the accepting edge, whatever the sign bits are. `done` is 1 only in the sixth of those cycles.
- R5: While `busy` is 1, `start` is ignored. This includes the cycle in which `done` is high. The result, the timing and the product registers are unchanged by it.
- R6: Operands are captured at acceptance of a signed request. Changes on `opa`, `opb` and `mode_sgn` during the sequence have no effect.
- R7: `done` is a single-cycle pulse per request. The product registers hold their value while the unit is idle.
- R8: During a signed sequence the product registers are visible at each step. In busy cycles 2 and 3 they hold the unsigned product. In busy cycles 4 and 5 `prod_hi` equals the unsigned upper byte minus `opa` if `opb`[7] is 1, and is unchanged otherwise. The second correction appears only in cycle 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled when not busy |
| mode_sgn | input | 1 | 1 = signed request, 0 = unsigned |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| busy | output | 1 | Signed sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | 8 | Upper product byte |
| prod_lo | output | 8 | Lower product byte |

## Verification
Two events can fall in the same cycle: the completion pulse of a signed sequence and a fresh request. The bench holds `start` high, with new operands and the unsigned mode, through the whole signed sequence, including the cycle in which `done` rises. It then checks three things: the signed result is the one for the first operands, `done` falls after one cycle, and no unsigned product overwrites the registers. The opposite case is an unsigned `done` coinciding with the next unsigned request. This is provoked by the back-to-back unsigned sweep, where every request must be accepted and every result must appear one cycle later.

// File: rtl/mul8_sc.sv
module mul8_sc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode_sgn,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);

  typedef enum logic [2:0] {
    S_IDLE, S_MUL, S_CHK2, S_SUB1, S_CHK1, S_SUB2, S_DONE
  } st_t;

  st_t            st;
  logic [W-1:0]   a_q, b_q;
  logic           sub_en;
  logic           udone;
  logic [W-1:0]   mx, my;
  logic [2*W-1:0] uprod;

  wire take = start && (st == S_IDLE);

  assign mx    = (st == S_IDLE) ? opa : a_q;
  assign my    = (st == S_IDLE) ? opb : b_q;
  assign uprod = mx * my;

  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE) || udone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      sub_en  <= 1'b0;
      udone   <= 1'b0;
      prod_hi <= '0;
      prod_lo <= '0;
    end else begin
      udone <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (mode_sgn) begin
            a_q <= opa;
            b_q <= opb;
            st  <= S_MUL;
          end else begin
            {prod_hi, prod_lo} <= uprod;
            udone <= 1'b1;
          end
        end
        S_MUL: begin
          {prod_hi, prod_lo} <= uprod;
          st <= S_CHK2;
        end
        S_CHK2: begin
          sub_en <= b_q[W-1];
          st     <= S_SUB1;
        end
        S_SUB1: begin
          if (sub_en) prod_hi <= prod_hi - a_q;
          st <= S_CHK1;
        end
        S_CHK1: begin
          sub_en <= a_q[W-1];
          st     <= S_SUB2;
        end
        S_SUB2: begin
          if (sub_en) prod_hi <= prod_hi - b_q;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_unsigned_now: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !mode_sgn) |=>
      ({prod_hi, prod_lo} == $past(opa) * $past(opb)) && done && !busy);

  a_r4_done_after_sub2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUB2) |=> (done && busy));

  a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |=> (!busy && !done));

  a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q)));

  a_r3_low_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK2 || st == S_SUB1 || st == S_CHK1 || st == S_SUB2) |=> $stable(prod_lo));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));

endmodule

// File: tb/mul8_sc_tb.sv
module mul8_sc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mode_sgn = 1'b0;
  logic [7:0] opa = '0, opb = '0;
  logic       busy, done;
  logic [7:0] prod_hi, prod_lo;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mul8_sc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sgn(mode_sgn),
    .opa(opa), .opb(opb), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sref(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] ea, eb;
    ea = {{8{a[7]}}, a};
    eb = {{8{b[7]}}, b};
    return ea * eb;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk({prod_hi, prod_lo} == 16'h0, "R1 product", {prod_hi, prod_lo}, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
  endtask

  task automatic t_unsigned_sweep();
    logic [15:0] exp_p;
    bit have = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (have) begin
        chk({prod_hi, prod_lo} == exp_p, "R2 unsigned product", {prod_hi, prod_lo}, exp_p);
        chk(done && !busy, "R2 done/busy", {busy, done}, 1);
      end
      start = 1'b1; mode_sgn = 1'b0;
      opa = i[15:8]; opb = i[7:0];
      exp_p = {8'h0, opa} * {8'h0, opb};
      have = 1;
    end
    @(negedge clk);
    start = 1'b0;
    chk({prod_hi, prod_lo} == exp_p, "R2 last product", {prod_hi, prod_lo}, exp_p);
    @(negedge clk);
    chk(done == 1'b0, "R7 single pulse", done, 0);
  endtask

  task automatic t_signed(input logic [7:0] a, input logic [7:0] b, input bit detail);
    logic [15:0] up, sp;
    logic [7:0]  mid;
    up  = {8'h0, a} * {8'h0, b};
    sp  = sref(a, b);
    mid = up[15:8] - (b[7] ? a : 8'h0);
    @(negedge clk);
    start = 1'b1; mode_sgn = 1'b1; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      if (detail) begin
        chk(busy == 1'b1, "R4 busy", busy, 1);
        chk(done == (k == 6), "R4 done timing", done, (k == 6));
        if (k == 2 || k == 3)
          chk({prod_hi, prod_lo} == up, "R8 unsigned stage", {prod_hi, prod_lo}, up);
        if (k == 4 || k == 5)
          chk({prod_hi, prod_lo} == {mid, up[7:0]}, "R8 first correction", {prod_hi, prod_lo}, {mid, up[7:0]});
      end
    end
    chk(done == 1'b1, "R4 done in sixth cycle", done, 1);
    chk({prod_hi, prod_lo} == sp, "R3 signed product", {prod_hi, prod_lo}, sp);
    chk(prod_lo == up[7:0], "R3 low byte", prod_lo, up[7:0]);
    @(negedge clk);
    chk(!busy && !done, "R4 end of sequence", {busy, done}, 0);
  endtask

  task automatic t_signed_sweep();
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 32; j++)
        t_signed(a[7:0], 8'((j * 8) + (a & 7)), 1'b0);
  endtask

  task automatic t_signed_corners();
    t_signed(8'h05, 8'h07, 1'b1);
    t_signed(8'hFB, 8'h07, 1'b1);
    t_signed(8'h05, 8'hF9, 1'b1);
    t_signed(8'h80, 8'h80, 1'b1);
    t_signed(8'hFF, 8'h01, 1'b1);
    t_signed(8'h7F, 8'h80, 1'b1);
  endtask

  task automatic t_busy_start();
    logic [15:0] sp;
    sp = sref(8'h85, 8'h7B);
    @(negedge clk);
    start = 1'b1; mode_sgn = 1'b1; opa = 8'h85; opb = 8'h7B;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      mode_sgn = 1'b0; opa = 8'hFF - 8'(k); opb = 8'h11 * 8'(k);
      if (k == 6) chk(done == 1'b1, "R5 done with start high", done, 1);
    end
    @(negedge clk);
    start = 1'b0;
    chk({prod_hi, prod_lo} == sp, "R5 start ignored while busy", {prod_hi, prod_lo}, sp);
    chk(!done && !busy, "R5 no extra completion", {busy, done}, 0);
    @(negedge clk);
    chk({prod_hi, prod_lo} == sp, "R6 operands captured", {prod_hi, prod_lo}, sp);
  endtask

  task automatic t_hold();
    logic [15:0] keep;
    keep = {prod_hi, prod_lo};
    opa = 8'h3C; opb = 8'hC3;
    repeat (5) @(negedge clk);
    chk({prod_hi, prod_lo} == keep, "R7 hold while idle", {prod_hi, prod_lo}, keep);
    chk(done == 1'b0, "R7 no done while idle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_unsigned_sweep();
    t_signed_corners();
    t_busy_start();
    t_hold();
    t_signed_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule